// File: doc/BRIEF.md
# SPI Transmit Queue with Status Flags

This block queues outgoing words for an SPI controller. Each entry is a word that carries the frame data together with its per-frame command bits. The host side, which is either a CPU or a DMA engine, pushes entries through a single write port. The shift-register side pulls the oldest entry when a transfer starts and signals when that transfer has finished. The queue depth is a parameter and defaults to four entries.

The block reports its state through these outputs:
- an entry count;
- the index of the slot that the next transfer will use;
- a fill flag, which is routed to either a DMA request or an interrupt request by a configuration input;
- a sticky transfer-done flag;
- a sticky underflow flag, which is raised when an external master clocks a frame in slave mode while the queue holds nothing.

A one-cycle flush pulse empties the queue. Each flag has its own write-one-to-clear pulse input.

Transfers are tracked by a two-state machine. `ST_IDLE` waits for a transfer start. `ST_SHIFT` waits for the transfer to end. There are three transitions:
- IDLE→SHIFT on a start when the queue is non-empty, which takes one entry.
- IDLE→SHIFT on a start in slave mode when the queue is empty, which raises the underflow flag.
- SHIFT→IDLE on the end pulse, which raises the done flag.

In every other case the machine holds its state.

Top module: `spi_txq`

## Requirements
- R1: After reset the count is 0, the next-slot index is 0, the fill flag is 1, the done and underflow flags are 0, and the machine is in `ST_IDLE`.
- R2: A push while the count is below DEPTH is accepted. The count rises by one, and entries leave in the order they were pushed.
- R3: A push while the count equals DEPTH is dropped. The count and the stored entries stay the same, and no error output exists or changes.
- R4: A `xfer_start` in `ST_IDLE` with a non-empty queue pulses `load_valid` in that same cycle, with `load_data` equal to the oldest entry. In the next cycle the count is one lower and `next_ptr` has advanced by one, wrapping from DEPTH-1 to 0.
- R5: When an entry is taken and a push is accepted in the same cycle, the count does not change. When the queue is full, a push in the same cycle as a take is still dropped.
- R6: The fill flag is updated in this order of priority. A `clr_fill` pulse clears it. Otherwise it is set whenever the queue count after the update is below DEPTH. Otherwise a DMA push that fills the queue clears it. A CPU push that fills the queue leaves it unchanged.
- R7: A `flush_req` pulse leaves the count at 0 in the next cycle and does not move `next_ptr`. It overrides any push or take in the same cycle.
- R8: `xfer_end` in `ST_SHIFT` sets `done_flag`, which stays set until `clr_done`. If both happen in the same cycle, the set wins.
- R9: A `xfer_start` in `ST_IDLE` with an empty queue sets `uflow_flag` only when `slave_mode` is 1. The flag stays set until `clr_uflow`, and a set wins over a clear in the same cycle.
- R10: When `req_sel` is 1, `dma_req` follows the fill flag and `irq_req` is 0. When `req_sel` is 0, `irq_req` follows the fill flag and `dma_req` is 0.
- R11: In `ST_SHIFT`, `xfer_start` is ignored. In master mode (`slave_mode` 0), a start with an empty queue leaves the machine in `ST_IDLE` and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slave_mode | input | 1 | 1 when an external master clocks transfers |
| req_sel | input | 1 | Fill request routing: 1 selects DMA, 0 selects interrupt |
| wr_valid | input | 1 | Push strobe |
| wr_data | input | WIDTH | Entry to push (data and command bits) |
| wr_from_dma | input | 1 | The current push comes from the DMA engine |
| flush_req | input | 1 | Empties the queue |
| clr_fill | input | 1 | Write-one-to-clear for the fill flag |
| clr_done | input | 1 | Write-one-to-clear for the done flag |
| clr_uflow | input | 1 | Write-one-to-clear for the underflow flag |
| xfer_start | input | 1 | Shifter begins a frame |
| xfer_end | input | 1 | Shifter finished the frame |
| load_valid | output | 1 | An entry is taken this cycle |
| load_data | output | WIDTH | Oldest entry |
| entry_count | output | $clog2(DEPTH+1) | Valid entries |
| next_ptr | output | $clog2(DEPTH) | Slot used by the next transfer |
| fill_flag | output | 1 | Room-available status |
| done_flag | output | 1 | Sticky transfer complete |
| uflow_flag | output | 1 | Sticky slave underflow |
| dma_req | output | 1 | Fill flag routed to DMA |
| irq_req | output | 1 | Fill flag routed to interrupt |

## Verification
The assertions assume the following about the inputs:
- `flush_req` and the clear pulses last one cycle each.
- `xfer_end` arrives only after a start has moved the machine to `ST_SHIFT`.
- A flush never coincides with a transfer start.

The stimulus drives every control from a single step task that raises the inputs for exactly one cycle. It sends an end pulse only after a start that was accepted, and it keeps flush steps apart from start steps. The sweep walks every fill level from empty to full under both routing settings and both modes.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } txq_state_t;
endpackage

// File: rtl/spi_txq_store.sv
module spi_txq_store #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic                       flush,
    input  logic [WIDTH-1:0]           din,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [$clog2(DEPTH)-1:0]   rd_ptr,
    output logic                       full,
    output logic                       empty,
    output logic                       full_nxt
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int PW = $clog2(DEPTH);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH-1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [CW-1:0]    count_nxt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        count_nxt = count;
        if (flush) begin
            count_nxt = '0;
        end else begin
            unique case ({push, pop})
                2'b10:   count_nxt = count + 1'b1;
                2'b01:   count_nxt = count - 1'b1;
                default: count_nxt = count;
            endcase
        end
    end

    assign full     = (count == FULL_CNT);
    assign empty    = (count == '0);
    assign full_nxt = (count_nxt == FULL_CNT);
    assign head     = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            slots[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_nxt;
            if (flush) begin
                wr_ptr <= rd_ptr;
            end else begin
                if (push) wr_ptr <= bump(wr_ptr);
                if (pop)  rd_ptr <= bump(rd_ptr);
            end
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
endmodule

// File: rtl/spi_txq_flags.sv
module spi_txq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic full_nxt,
    input  logic dma_fill,
    input  logic clr_fill,
    input  logic clr_done,
    input  logic clr_uflow,
    input  logic done_set,
    input  logic uf_set,
    input  logic req_sel,
    output logic fill_flag,
    output logic done_flag,
    output logic uflow_flag,
    output logic dma_req,
    output logic irq_req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_flag  <= 1'b1;
            done_flag  <= 1'b0;
            uflow_flag <= 1'b0;
        end else begin
            if (clr_fill)      fill_flag <= 1'b0;
            else if (!full_nxt) fill_flag <= 1'b1;
            else if (dma_fill)  fill_flag <= 1'b0;

            if (done_set)      done_flag <= 1'b1;
            else if (clr_done) done_flag <= 1'b0;

            if (uf_set)         uflow_flag <= 1'b1;
            else if (clr_uflow) uflow_flag <= 1'b0;
        end
    end

    assign dma_req = fill_flag &  req_sel;
    assign irq_req = fill_flag & ~req_sel;

    assert_req_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_req, irq_req}));
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag && !clr_done |=> done_flag);
    assert_uflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_flag && !clr_uflow |=> uflow_flag);
endmodule

// File: rtl/spi_txq.sv
module spi_txq
    import spi_txq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       slave_mode,
    input  logic                       req_sel,
    input  logic                       wr_valid,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       wr_from_dma,
    input  logic                       flush_req,
    input  logic                       clr_fill,
    input  logic                       clr_done,
    input  logic                       clr_uflow,
    input  logic                       xfer_start,
    input  logic                       xfer_end,
    output logic                       load_valid,
    output logic [WIDTH-1:0]           load_data,
    output logic [$clog2(DEPTH+1)-1:0] entry_count,
    output logic [$clog2(DEPTH)-1:0]   next_ptr,
    output logic                       fill_flag,
    output logic                       done_flag,
    output logic                       uflow_flag,
    output logic                       dma_req,
    output logic                       irq_req
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int PW = $clog2(DEPTH);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH-1);

    txq_state_t       state_q, state_d;
    logic             full, empty, full_nxt;
    logic             push_ok, pop_go, uf_hit, done_hit;
    logic [WIDTH-1:0] head;

    assign push_ok = wr_valid && !full && !flush_req;

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        pop_go   = 1'b0;
        uf_hit   = 1'b0;
        done_hit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (xfer_start && !flush_req) begin
                    if (!empty) begin
                        pop_go  = 1'b1;
                        state_d = ST_SHIFT;
                    end else if (slave_mode) begin
                        uf_hit  = 1'b1;
                        state_d = ST_SHIFT;
                    end
                end
            end
            ST_SHIFT: begin
                if (xfer_end) begin
                    done_hit = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs toward the shifter
    always_comb begin
        load_valid = pop_go;
        load_data  = head;
    end

    spi_txq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_ok),
        .pop      (pop_go),
        .flush    (flush_req),
        .din      (wr_data),
        .head     (head),
        .count    (entry_count),
        .rd_ptr   (next_ptr),
        .full     (full),
        .empty    (empty),
        .full_nxt (full_nxt)
    );

    spi_txq_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .full_nxt   (full_nxt),
        .dma_fill   (push_ok && wr_from_dma),
        .clr_fill   (clr_fill),
        .clr_done   (clr_done),
        .clr_uflow  (clr_uflow),
        .done_set   (done_hit),
        .uf_set     (uf_hit),
        .req_sel    (req_sel),
        .fill_flag  (fill_flag),
        .done_flag  (done_flag),
        .uflow_flag (uflow_flag),
        .dma_req    (dma_req),
        .irq_req    (irq_req)
    );

    assert_full_push_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_count == FULL_CNT) && wr_valid && !load_valid && !flush_req
        |=> (entry_count == FULL_CNT) && $stable(next_ptr));
    assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid && !flush_req
        |=> next_ptr == (($past(next_ptr) == LAST_SLOT) ? '0 : $past(next_ptr) + 1'b1));
    assert_pushpop_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid && wr_valid && (entry_count != FULL_CNT) && !flush_req
        |=> $stable(entry_count));
    assert_fill_when_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_flag |-> (entry_count == FULL_CNT) || $past(clr_fill));
    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> entry_count == '0);
    assert_uflow_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && xfer_start && slave_mode && (entry_count == '0) && !flush_req
        |=> uflow_flag);
    assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) && !xfer_end |=> state_q == ST_SHIFT);
endmodule

// File: tb/spi_txq_tb.sv
module spi_txq_tb;
    localparam int CLK_P = 10;
    localparam int DEPTH = 4;
    localparam int WIDTH = 32;
    localparam int CW = $clog2(DEPTH+1);
    localparam int PW = $clog2(DEPTH);

    logic clk = 0, rst_n = 0;
    logic slave_mode = 0, req_sel = 0, wr_valid = 0, wr_from_dma = 0;
    logic [WIDTH-1:0] wr_data = '0;
    logic flush_req = 0, clr_fill = 0, clr_done = 0, clr_uflow = 0;
    logic xfer_start = 0, xfer_end = 0;
    logic load_valid, fill_flag, done_flag, uflow_flag, dma_req, irq_req;
    logic [WIDTH-1:0] load_data;
    logic [CW-1:0] entry_count;
    logic [PW-1:0] next_ptr;

    int checks = 0, fails = 0, wseq = 0;
    logic [WIDTH-1:0] mq[$];
    int mptr = 0;
    bit mbusy = 0, mfill = 1, mdone = 0, muf = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_txq #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .req_sel(req_sel),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_from_dma(wr_from_dma),
        .flush_req(flush_req), .clr_fill(clr_fill), .clr_done(clr_done),
        .clr_uflow(clr_uflow), .xfer_start(xfer_start), .xfer_end(xfer_end),
        .load_valid(load_valid), .load_data(load_data), .entry_count(entry_count),
        .next_ptr(next_ptr), .fill_flag(fill_flag), .done_flag(done_flag),
        .uflow_flag(uflow_flag), .dma_req(dma_req), .irq_req(irq_req)
    );

    task automatic cmp(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        cmp(tag, "count", entry_count, mq.size());
        cmp(tag, "next_ptr", next_ptr, mptr);
        cmp(tag, "fill", fill_flag, mfill);
        cmp(tag, "done", done_flag, mdone);
        cmp(tag, "uflow", uflow_flag, muf);
        cmp({tag, "/R10"}, "dma_req", dma_req, mfill & req_sel);
        cmp({tag, "/R10"}, "irq_req", irq_req, mfill & ~req_sel);
    endtask

    function automatic logic [WIDTH-1:0] nw();
        wseq++;
        return 32'hC0DE_0000 + WIDTH'(wseq);
    endfunction

    // One cycle of stimulus plus model update; inputs change at posedge+1
    task automatic step(string tag, bit p, logic [WIDTH-1:0] w, bit d, bit st,
                        bit en, bit fl, bit cf, bit cd, bit cu);
        int sz;
        bit pop, uf, pk, dn;
        wr_valid = p; wr_data = w; wr_from_dma = d; xfer_start = st;
        xfer_end = en; flush_req = fl; clr_fill = cf; clr_done = cd; clr_uflow = cu;
        #1;
        sz  = mq.size();
        pop = st && !mbusy && !fl && sz > 0;
        uf  = st && !mbusy && !fl && sz == 0 && slave_mode;
        pk  = p && sz < DEPTH && !fl;
        dn  = en && mbusy;
        cmp({tag, "/R4"}, "load_valid", load_valid, pop);
        if (pop) cmp({tag, "/R4"}, "load_data", load_data, mq[0]);
        if (fl) mq.delete();
        else begin
            if (pop) begin void'(mq.pop_front()); mptr = (mptr + 1) % DEPTH; end
            if (pk) mq.push_back(w);
        end
        if (dn) mbusy = 0; else if (pop || uf) mbusy = 1;
        if (dn) mdone = 1; else if (cd) mdone = 0;
        if (uf) muf = 1; else if (cu) muf = 0;
        if (cf) mfill = 0;
        else if (mq.size() != DEPTH) mfill = 1;
        else if (pk && d) mfill = 0;
        @(posedge clk); #1;
        wr_valid = 0; wr_from_dma = 0; xfer_start = 0; xfer_end = 0;
        flush_req = 0; clr_fill = 0; clr_done = 0; clr_uflow = 0;
        check_all(tag);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        rst_n = 1;
        @(posedge clk); #1;
        check_all("R1");

        // Sweep every fill level under both request routings
        for (int sel = 0; sel < 2; sel++) begin
            req_sel = sel[0];
            for (int lvl = 0; lvl <= DEPTH; lvl++) begin
                step("R7", 0, '0, 0, 0, 0, 1, 0, 0, 0);
                for (int i = 0; i < lvl; i++) step("R2", 1, nw(), lvl[0], 0, 0, 0, 0, 0, 0);
                step("R3", 1, nw(), 0, 0, 0, 0, 0, 0, 0);
                while (mq.size() > 0) begin
                    step("R4", 0, '0, 0, 1, 0, 0, 0, 0, 0);
                    step("R11", 0, '0, 0, 1, 0, 0, 0, 0, 0);
                    step("R8", 0, '0, 0, 0, 1, 0, 0, 0, 0);
                    step("R8", 0, '0, 0, 0, 0, 0, 0, 1, 0);
                end
                step("R11", 0, '0, 0, 1, 0, 0, 0, 0, 0);
                slave_mode = 1;
                step("R9", 0, '0, 0, 1, 0, 0, 0, 0, 0);
                step("R8", 0, '0, 0, 0, 1, 0, 0, 1, 0);
                step("R9", 0, '0, 0, 0, 0, 0, 0, 1, 1);
                slave_mode = 0;
            end
        end

        // Push and take in the same cycle at every level
        req_sel = 0;
        for (int lvl = 1; lvl <= DEPTH; lvl++) begin
            step("R7", 0, '0, 0, 0, 0, 1, 0, 0, 0);
            for (int i = 0; i < lvl; i++) step("R2", 1, nw(), 0, 0, 0, 0, 0, 0, 0);
            step("R5", 1, nw(), 0, 1, 0, 0, 0, 0, 0);
            step("R5", 0, '0, 0, 0, 1, 0, 0, 1, 0);
            while (mq.size() > 0) begin
                step("R4", 0, '0, 0, 1, 0, 0, 0, 0, 0);
                step("R8", 0, '0, 0, 0, 1, 0, 0, 0, 0);
            end
        end

        // Fill flag rules with DMA routing
        req_sel = 1;
        step("R7", 0, '0, 0, 0, 0, 1, 0, 1, 1);
        for (int i = 0; i < DEPTH; i++) step("R6", 1, nw(), 1, 0, 0, 0, 0, 0, 0);
        step("R6", 0, '0, 0, 1, 0, 0, 0, 0, 0);
        step("R6", 0, '0, 0, 0, 1, 0, 1, 0, 0);
        step("R6", 0, '0, 0, 0, 0, 0, 0, 0, 0);
        step("R6", 1, nw(), 0, 0, 0, 0, 0, 0, 0);
        step("R6", 0, '0, 0, 0, 0, 0, 1, 0, 0);
        step("R3", 1, nw(), 1, 0, 0, 0, 0, 0, 0);
        step("R7", 1, nw(), 0, 0, 0, 1, 0, 0, 0);
        step("R2", 1, nw(), 0, 0, 0, 0, 0, 0, 0);
        step("R4", 0, '0, 0, 1, 0, 0, 0, 0, 0);
        step("R8", 0, '0, 0, 0, 1, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule